// File: doc/BRIEF.md
# Satellite Control Tone Generator

This block makes a square-wave control tone, typically around 22 kHz, for the control line of a satellite low-noise block. It runs from one fast master clock and needs no second clock. A 2-bit prescaler code selects a tick rate of one, two, four or twelve master cycles. The high part of the wave lasts a 15-bit number of ticks, and the low part lasts a separate 15-bit number of ticks. The block also registers a static supply-select bit, which picks the lower or the higher supply voltage.

All inputs are plain control levels and need no handshake; nothing streams into or out of the block. The tone settings are sampled only at a period boundary, so software can rewrite them at any time without producing a short or a stretched pulse. While the wave is oscillating, a period boundary is the end of a low phase. While the output is flat, every tick is a period boundary. A period always begins with its high phase. Reset forces both outputs low, and the tone stays flat.

Top module: `lnb_tone_gen`

## Requirements
- R1: Prescaler code `pre_sel` sets the tick length in master clock cycles: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 12.
- R2: When both counts are nonzero, `tone_out` repeats a period made of `hi_len` ticks at 1 followed by `lo_len` ticks at 0.
- R3: While `rst_n` is low, `tone_out` and `supply_out` are both 0. After release, the output stays flat until the first tick applies the inputs.
- R4: When both counts are zero, `tone_out` stays constantly at 0.
- R5: When `lo_len` is zero and `hi_len` is nonzero, `tone_out` stays constantly at 1. When `hi_len` is zero and `lo_len` is nonzero, `tone_out` stays constantly at 0.
- R6: A change of `pre_sel`, `hi_len` or `lo_len` during an oscillating period, whether in its high or its low phase, leaves that period unchanged. The new values apply from the next period onward, and `tone_out` changes level only on ticks.
- R7: `supply_out` equals `supply_sel` as it was one clock earlier (0 = low supply level, 1 = high).
- R8: With prescaler code 2'b01 and both counts 0x1FF, one period is 2044 master cycles, which is about 22 kHz from a 45 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Prescaler code |
| hi_len | input | 15 | High-phase length in ticks |
| lo_len | input | 15 | Low-phase length in ticks |
| supply_sel | input | 1 | Supply level request |
| tone_out | output | 1 | Control tone |
| supply_out | output | 1 | Registered supply level select |

## Verification
The bench times every high run and every low run in master cycles and checks each against count times ratio for all four prescaler codes. A wrong ratio, or a counter that is off by one, shows up as a run that is one tick too long or too short. Settings are also rewritten in the middle of a high phase and in the middle of a low phase. A design that loads them straight away would cut the running phase short or stretch it, instead of finishing the old period. Flat cases (one count zero, or both zero) are held for a long window, which would reveal a design that still toggles or settles at the wrong level. A period of one tick high and one tick low, and the 2044-cycle example, complete the set.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;

  typedef enum logic [1:0] {
    PRE_BY1  = 2'b00,
    PRE_BY2  = 2'b01,
    PRE_BY4  = 2'b10,
    PRE_BY12 = 2'b11
  } pre_code_e;

  localparam int unsigned RATIO_A = 1;
  localparam int unsigned RATIO_B = 2;
  localparam int unsigned RATIO_C = 4;
  localparam int unsigned RATIO_D = 12;
  localparam int unsigned PRE_CW  = $clog2(RATIO_D);

  // Index of the last master cycle inside one tick.
  function automatic logic [PRE_CW-1:0] pre_last(input pre_code_e code);
    case (code)
      PRE_BY1: return PRE_CW'(RATIO_A - 1);
      PRE_BY2: return PRE_CW'(RATIO_B - 1);
      PRE_BY4: return PRE_CW'(RATIO_C - 1);
      default: return PRE_CW'(RATIO_D - 1);
    endcase
  endfunction

endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler
  import tonegen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pre_code_e code,
  output logic      tick
);

  logic [PRE_CW-1:0] div_q;
  logic [PRE_CW-1:0] last;

  assign last = pre_last(code);
  assign tick = (div_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  // R1: a tick restarts the cycle count
  assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> div_q == '0);

  // R1: between ticks the count steps by one
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> div_q == PRE_CW'($past(div_q) + 1'b1));

endmodule

// File: rtl/tg_cfg_shadow.sv
module tg_cfg_shadow
  import tonegen_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       new_code,
  input  logic [CNT_W-1:0] new_lo,
  output pre_code_e        act_code,
  output logic [CNT_W-1:0] act_lo
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= PRE_BY1;
      act_lo   <= '0;
    end else if (load) begin
      act_code <= pre_code_e'(new_code);
      act_lo   <= new_lo;
    end
  end

  // R6: the active settings move only at a period boundary
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_code) && $stable(act_lo));

endmodule

// File: rtl/tg_phase_timer.sv
module tg_phase_timer #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] nxt_hi,
  input  logic [CNT_W-1:0] nxt_lo,
  input  logic [CNT_W-1:0] act_lo,
  output logic             load,
  output logic             tone
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             flat_q;
  logic             in_high_q;
  logic             tone_q;
  logic [CNT_W-1:0] left_q;
  logic             last_tick;
  logic             nxt_run;
  logic             nxt_flat_hi;

  assign last_tick   = (left_q == ONE);
  assign load        = tick && (flat_q || (!in_high_q && last_tick));
  assign nxt_run     = (nxt_hi != '0) && (nxt_lo != '0);
  assign nxt_flat_hi = (nxt_hi != '0) && (nxt_lo == '0);
  assign tone        = tone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flat_q    <= 1'b1;
      in_high_q <= 1'b0;
      tone_q    <= 1'b0;
      left_q    <= '0;
    end else if (load) begin
      if (nxt_run) begin
        flat_q    <= 1'b0;
        in_high_q <= 1'b1;
        left_q    <= nxt_hi;
        tone_q    <= 1'b1;
      end else begin
        flat_q    <= 1'b1;
        in_high_q <= 1'b0;
        left_q    <= '0;
        tone_q    <= nxt_flat_hi;
      end
    end else if (tick) begin
      if (last_tick) begin
        in_high_q <= 1'b0;
        left_q    <= act_lo;
        tone_q    <= 1'b0;
      end else begin
        left_q    <= left_q - ONE;
      end
    end
  end

  // R6: the line moves only on a tick, never between ticks
  assert_edge_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tone_q));

  // R2: an oscillating phase never holds an empty count
  assert_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flat_q |-> left_q != '0);

  // R5: a flat line stays put until the next boundary
  assert_flat_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flat_q && !load) |=> $stable(tone_q));

endmodule

// File: rtl/lnb_tone_gen.sv
module lnb_tone_gen
  import tonegen_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pre_sel,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  input  logic             supply_sel,
  output logic             tone_out,
  output logic             supply_out
);

  pre_code_e        act_code;
  logic [CNT_W-1:0] act_lo;
  logic             tick;
  logic             load;
  logic             supply_q;

  tg_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (act_code),
    .tick  (tick)
  );

  tg_cfg_shadow #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .new_code (pre_sel),
    .new_lo   (lo_len),
    .act_code (act_code),
    .act_lo   (act_lo)
  );

  tg_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .nxt_hi (hi_len),
    .nxt_lo (lo_len),
    .act_lo (act_lo),
    .load   (load),
    .tone   (tone_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) supply_q <= 1'b0;
    else        supply_q <= supply_sel;
  end
  assign supply_out = supply_q;

  // R3: reset holds both outputs low
  assert_reset_quiet_R3: assert property (@(posedge clk)
    !rst_n |-> !tone_out && !supply_out);

  // R7: supply select follows its request one clock later
  assert_supply_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> supply_out == $past(supply_sel));

endmodule

// File: tb/sim_lnb_tone_gen.sv
module sim_lnb_tone_gen;

  localparam int CNT_W = 15;
  localparam int WD_CYCLES = 150000;

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       pre_sel = 2'b00;
  logic [CNT_W-1:0] hi_len = '0;
  logic [CNT_W-1:0] lo_len = '0;
  logic             supply_sel = 1'b0;
  logic             tone_out;
  logic             supply_out;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  bit   arm = 0;
  bit   synced = 0;
  bit   prev_lvl = 0;
  int   run_len = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  lnb_tone_gen #(.CNT_W(CNT_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_sel    (pre_sel),
    .hi_len     (hi_len),
    .lo_len     (lo_len),
    .supply_sel (supply_sel),
    .tone_out   (tone_out),
    .supply_out (supply_out)
  );

  function automatic int ratio(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 12;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: times completed runs after the first rising edge and scores them.
  always @(negedge clk) begin
    if (arm) begin
      if (tone_out != prev_lvl) begin
        if (synced && q.size() > 0) begin
          total++;
          if (prev_lvl != q[0].lvl || run_len != q[0].len) begin
            bad++;
            $display("FAIL %s actual=lvl%0d/%0d expected=lvl%0d/%0d",
                     q[0].req, prev_lvl, run_len, q[0].lvl, q[0].len);
          end
          void'(q.pop_front());
          if (q.size() == 0) arm = 0;
        end else if (tone_out) begin
          synced = 1;
        end
        run_len = 1;
      end else begin
        run_len++;
      end
    end
    prev_lvl = tone_out;
  end

  task automatic set_cfg(input logic [1:0] c, input int h, input int l);
    @(negedge clk);
    pre_sel = c;
    hi_len  = CNT_W'(h);
    lo_len  = CNT_W'(l);
  endtask

  task automatic push_period(input logic [1:0] c, input int h, input int l, input string req);
    q.push_back('{1'b1, h * ratio(c), req});
    q.push_back('{1'b0, l * ratio(c), req});
  endtask

  task automatic start_monitor();
    @(negedge clk);
    synced = 0;
    arm = 1;
  endtask

  task automatic wave(input logic [1:0] c, input int h, input int l, input string req);
    set_cfg(c, h, l);
    push_period(c, h, l, req);
    push_period(c, h, l, req);
    start_monitor();
    while (arm) @(negedge clk);
  endtask

  // R6: rewrite the settings inside the first scored period
  task automatic mid_change(input logic [1:0] c0, input int h0, input int l0,
                            input logic [1:0] c1, input int h1, input int l1,
                            input bit in_low);
    set_cfg(c0, h0, l0);
    push_period(c0, h0, l0, "R6 old period");
    push_period(c1, h1, l1, "R6 new period");
    start_monitor();
    while (!synced) @(negedge clk);
    if (in_low) while (tone_out) @(negedge clk);
    pre_sel = c1;
    hi_len  = CNT_W'(h1);
    lo_len  = CNT_W'(l1);
    while (arm) @(negedge clk);
  endtask

  task automatic flat(input string req, input bit lvl, input int settle, input int n);
    int miss;
    int seen;
    miss = 0;
    seen = lvl;
    repeat (settle) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tone_out != lvl && miss == 0) begin
        miss = 1;
        seen = tone_out;
      end
    end
    check(req, seen, lvl);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R3: quiet during reset even with live settings
    pre_sel = 2'b00; hi_len = 3; lo_len = 3; supply_sel = 1'b1;
    repeat (3) @(negedge clk);
    flat("R3 tone held in reset", 1'b0, 0, 8);
    check("R3 supply held in reset", supply_out, 0);
    hi_len = 0; lo_len = 0; supply_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R4: both counts zero gives a flat low line
    flat("R4 both zero low", 1'b0, 0, 40);

    // R1 / R2: all prescaler codes
    wave(2'b00, 3, 5, "R2 div1 h3 l5");
    wave(2'b01, 4, 2, "R1 div2 h4 l2");
    wave(2'b10, 2, 3, "R1 div4 h2 l3");
    wave(2'b11, 3, 1, "R1 div12 h3 l1");
    wave(2'b00, 1, 1, "R2 minimum h1 l1");

    // R6: rewrite in the high phase, then in the low phase
    mid_change(2'b00, 4, 4, 2'b01, 3, 5, 1'b0);
    mid_change(2'b01, 3, 5, 2'b10, 2, 2, 1'b1);

    // R5: one count zero
    set_cfg(2'b10, 6, 0);
    flat("R5 lo zero stays high", 1'b1, 60, 80);
    set_cfg(2'b11, 0, 6);
    flat("R5 hi zero stays low", 1'b0, 60, 80);
    set_cfg(2'b00, 0, 0);
    flat("R4 back to both zero", 1'b0, 30, 40);

    // R8: the 22 kHz example period
    wave(2'b01, 'h1FF, 'h1FF, "R8 2044-cycle period");

    // R7: supply select
    @(negedge clk);
    supply_sel = 1'b1;
    @(negedge clk);
    check("R7 supply high", supply_out, 1);
    supply_sel = 1'b0;
    @(negedge clk);
    check("R7 supply low", supply_out, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule